// File: doc/BRIEF.md
# Descriptor Access-Rights Checker

This unit takes a segment selector and tells the caller whether the descriptor it names may be inspected at the current privilege level. When it may, the unit returns the descriptor's access-rights fields repacked into a fixed word. The caller pulses `start` together with the selector, the current privilege level, a long-mode flag and an operand-width flag. The unit then picks the global or the local descriptor table from the selector. It rejects a null selector and any entry outside the chosen table's limit. Otherwise it fetches the high doubleword of the 8-byte descriptor through a synchronous read port, then judges the type and the privilege.

The result appears with a one-cycle `done` pulse. On success `accessOk` is set and `rights` carries the formatted word. On failure `accessOk` is cleared and `rights` keeps its previous value. No memory access is made when the selector or limit test has already failed.

Top module: `descRightsCheck`

## Requirements
- R1: Bits 31:16 of `selectorIn` have no effect; the selector is `selectorIn[15:0]`, decoded as index = bits 15:3, table select = bit 2 (0 global, 1 local) and requested privilege RPL = bits 1:0.
- R2: A selector whose bits 15:2 are all zero is null. It fails with no memory read, and `done` is high in the second cycle after the cycle in which `start` was sampled.
- R3: Bit 2 chooses which base and limit are used. When index*8+7 exceeds that limit the request fails with no memory read; equality passes.
- R4: A request that passes R2 and R3 makes exactly one one-cycle read at base + index*8 + 4, with data taken in the following cycle. `done` is high in the fourth cycle after the `start` cycle.
- R5: A descriptor with S (bit 12) set is of acceptable type whatever its 4-bit type field (bits 11:8).
- R6: With `longMode` low and S clear, types 1, 2, 3, 4, 5, 9, 11 and 12 are accepted and all others rejected.
- R7: With `longMode` high and S clear, only types 9, 11 and 12 are accepted.
- R8: Unless the descriptor is conforming code (S set, type bits 3 and 2 set), the request fails when `cpl` or RPL is numerically greater than the descriptor's DPL (bits 14:13).
- R9: On success with `wideOp` low, `rights` = descriptor bits 15:8 placed at 15:8, all other bits zero.
- R10: On success with `wideOp` high, `rights` also carries descriptor bits 23:20 at 23:20, with bits 31:24, 19:16 and 7:0 zero.
- R11: On failure `accessOk` is 0 and `rights` keeps its previous value; on success `accessOk` is 1. Reset clears both.
- R12: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| selectorIn | input | 32 | Source operand; low 16 bits form the selector |
| cpl | input | 2 | Current privilege level |
| longMode | input | 1 | Selects the 64-bit system-type set |
| wideOp | input | 1 | Operand wider than 16 bits |
| gdtBase | input | ADDR_W | Global table byte base |
| gdtLimit | input | LIMIT_W | Global table byte limit |
| ldtBase | input | ADDR_W | Local table byte base |
| ldtLimit | input | LIMIT_W | Local table byte limit |
| memRdEn | output | 1 | Read strobe |
| memRdAddr | output | ADDR_W | Byte address of the descriptor high doubleword |
| memRdData | input | 32 | Read data, valid the cycle after `memRdEn` |
| done | output | 1 | One-cycle completion pulse |
| accessOk | output | 1 | Result flag |
| rights | output | 32 | Formatted access rights |

## Verification
The properties assume that the memory returns data exactly one cycle after the strobe. They also assume that `start` is only meaningful while the unit is idle, so the checker latches the selector on the same condition. The stimulus keeps every table inside the modelled memory by bounding the limits and aligning the bases. It issues each request only after the previous `done`, and it mixes random selectors, limits and table contents with directed descriptors crafted for each type, privilege and boundary case.

// File: rtl/descRightsPkg.sv
package descRightsPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK_SEL,
    ST_READ,
    ST_EVAL,
    ST_DONE
  } ctrlStateT;

  typedef struct packed {
    logic latchReq;
    logic issueRd;
    logic capDesc;
    logic commit;
    logic rejectEarly;
  } strobeT;

  // one bit per 4-bit system type, set when the type is acceptable
  localparam logic [15:0] LEGACY_SYS_OK = 16'h1A3E;
  localparam logic [15:0] LONG_SYS_OK   = 16'h1A00;

  localparam int SEL_W  = 16;
  localparam int DESC_W = 32;

endpackage

// File: rtl/descRightsCtrl.sv
module descRightsCtrl
  import descRightsPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   selPass,
  output strobeT strb,
  output logic   done,
  output logic   rdEn
);

  ctrlStateT stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.latchReq = 1'b1;
          stateD        = ST_CHECK_SEL;
        end
      end
      ST_CHECK_SEL: begin
        if (selPass) begin
          strb.issueRd = 1'b1;
          stateD       = ST_READ;
        end else begin
          strb.rejectEarly = 1'b1;
          stateD           = ST_DONE;
        end
      end
      ST_READ: begin
        strb.capDesc = 1'b1;
        stateD       = ST_EVAL;
      end
      ST_EVAL: begin
        strb.commit = 1'b1;
        stateD      = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign done = (stateQ == ST_DONE);
  assign rdEn = strb.issueRd;

endmodule

// File: rtl/descRightsPath.sv
module descRightsPath
  import descRightsPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [SEL_W-1:0]   selIn,
  input  logic [1:0]         cplIn,
  input  logic               longIn,
  input  logic               wideIn,
  input  logic [ADDR_W-1:0]  gdtBase,
  input  logic [LIMIT_W-1:0] gdtLimit,
  input  logic [ADDR_W-1:0]  ldtBase,
  input  logic [LIMIT_W-1:0] ldtLimit,
  input  logic [DESC_W-1:0]  memRdData,
  output logic               selPass,
  output logic [ADDR_W-1:0]  memRdAddr,
  output logic               accessOk,
  output logic [31:0]        rights
);

  localparam int CMP_W = (LIMIT_W > SEL_W) ? LIMIT_W : SEL_W;

  logic [SEL_W-1:0]   selReg;
  logic [1:0]         cplReg;
  logic               longReg;
  logic               wideReg;
  logic [ADDR_W-1:0]  baseReg;
  logic [LIMIT_W-1:0] limitReg;
  logic [15:0]        descFields;   // descriptor bits 23:8

  // request capture; table picked by the selector's table bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg   <= '0;
      cplReg   <= '0;
      longReg  <= 1'b0;
      wideReg  <= 1'b0;
      baseReg  <= '0;
      limitReg <= '0;
    end else if (strb.latchReq) begin
      selReg   <= selIn;
      cplReg   <= cplIn;
      longReg  <= longIn;
      wideReg  <= wideIn;
      baseReg  <= selIn[2] ? ldtBase  : gdtBase;
      limitReg <= selIn[2] ? ldtLimit : gdtLimit;
    end
  end

  logic [12:0]      entryIdx;
  logic [1:0]       reqPriv;
  logic             isNull;
  logic [CMP_W-1:0] lastByte;
  logic [CMP_W-1:0] limitExt;

  assign entryIdx = selReg[15:3];
  assign reqPriv  = selReg[1:0];
  assign isNull   = (selReg[15:2] == '0);
  assign lastByte = CMP_W'({entryIdx, 3'b111});
  assign limitExt = CMP_W'(limitReg);
  assign selPass  = !isNull && (lastByte <= limitExt);

  assign memRdAddr = baseReg + ADDR_W'({entryIdx, 3'b100});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             descFields <= '0;
    else if (strb.capDesc) descFields <= memRdData[23:8];
  end

  logic unusedDescBits;
  assign unusedDescBits = ^{memRdData[31:24], memRdData[7:0]};

  logic [3:0]  typeField;
  logic        sysFlag;
  logic [1:0]  descPriv;
  logic        conforming;
  logic [15:0] sysMask;
  logic        typeOk;
  logic        privOk;
  logic        evalPass;
  logic [31:0] packedRights;

  assign typeField  = descFields[3:0];
  assign sysFlag    = descFields[4];
  assign descPriv   = descFields[6:5];
  assign conforming = sysFlag & typeField[3] & typeField[2];
  assign sysMask    = longReg ? LONG_SYS_OK : LEGACY_SYS_OK;
  assign typeOk     = sysFlag | sysMask[typeField];
  assign privOk     = conforming | ((cplReg <= descPriv) & (reqPriv <= descPriv));
  assign evalPass   = typeOk & privOk;

  always_comb begin
    packedRights       = '0;
    packedRights[15:8] = descFields[7:0];
    if (wideReg) packedRights[23:20] = descFields[15:12];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessOk <= 1'b0;
      rights   <= '0;
    end else if (strb.rejectEarly) begin
      accessOk <= 1'b0;
    end else if (strb.commit) begin
      accessOk <= evalPass;
      if (evalPass) rights <= packedRights;
    end
  end

endmodule

// File: rtl/descRightsCheck.sv
module descRightsCheck
  import descRightsPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [31:0]        selectorIn,
  input  logic [1:0]         cpl,
  input  logic               longMode,
  input  logic               wideOp,
  input  logic [ADDR_W-1:0]  gdtBase,
  input  logic [LIMIT_W-1:0] gdtLimit,
  input  logic [ADDR_W-1:0]  ldtBase,
  input  logic [LIMIT_W-1:0] ldtLimit,
  output logic               memRdEn,
  output logic [ADDR_W-1:0]  memRdAddr,
  input  logic [31:0]        memRdData,
  output logic               done,
  output logic               accessOk,
  output logic [31:0]        rights
);

  strobeT strb;
  logic   selPass;

  logic unusedSelHigh;
  assign unusedSelHigh = ^selectorIn[31:16];

  descRightsCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .selPass (selPass),
    .strb    (strb),
    .done    (done),
    .rdEn    (memRdEn)
  );

  descRightsPath #(
    .ADDR_W  (ADDR_W),
    .LIMIT_W (LIMIT_W)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .selIn     (selectorIn[15:0]),
    .cplIn     (cpl),
    .longIn    (longMode),
    .wideIn    (wideOp),
    .gdtBase   (gdtBase),
    .gdtLimit  (gdtLimit),
    .ldtBase   (ldtBase),
    .ldtLimit  (ldtLimit),
    .memRdData (memRdData),
    .selPass   (selPass),
    .memRdAddr (memRdAddr),
    .accessOk  (accessOk),
    .rights    (rights)
  );

endmodule

// File: rtl/descRightsChecker.sv
module descRightsChecker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [31:0] selectorIn,
  input logic        memRdEn,
  input logic        done,
  input logic        accessOk,
  input logic [31:0] rights
);

  logic        busy;
  logic        sawRead;
  logic [15:0] selSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sawRead <= 1'b0;
      selSeen <= '0;
    end else begin
      if (!busy && start) begin
        busy    <= 1'b1;
        selSeen <= selectorIn[15:0];
        sawRead <= 1'b0;
      end else if (done) begin
        busy <= 1'b0;
      end
      if (memRdEn) sawRead <= 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn); // R4

  AST_OK_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (done && accessOk) |-> sawRead); // R4

  AST_NULL_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (selSeen[15:2] != 14'd0)); // R2

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !accessOk) |-> (rights == $past(rights))); // R11

  AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && accessOk) |-> (rights[7:0] == 8'd0 && rights[19:16] == 4'd0
                            && rights[31:24] == 8'd0)); // R9

endmodule

bind descRightsCheck descRightsChecker i_descRightsChecker (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .selectorIn (selectorIn),
  .memRdEn    (memRdEn),
  .done       (done),
  .accessOk   (accessOk),
  .rights     (rights)
);

// File: tb/test_descRightsCheck.sv
module test_descRightsCheck;

  localparam int ADDR_W  = 32;
  localparam int LIMIT_W = 16;
  localparam logic [31:0] GDT_BASE = 32'h0000_0040;
  localparam logic [31:0] LDT_BASE = 32'h0000_0800;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [31:0]        selectorIn = '0;
  logic [1:0]         cpl = '0;
  logic               longMode = 1'b0;
  logic               wideOp = 1'b0;
  logic [LIMIT_W-1:0] gdtLimit = 16'h03FF;
  logic [LIMIT_W-1:0] ldtLimit = 16'h01FF;
  logic               memRdEn;
  logic [ADDR_W-1:0]  memRdAddr;
  logic [31:0]        memRdData = '0;
  logic               done;
  logic               accessOk;
  logic [31:0]        rights;

  logic [31:0] mem [0:1023];

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int rdCount = 0;
  logic [31:0] lastAddr = '0;
  logic [31:0] heldRights = '0;

  always #5 clk = ~clk;

  descRightsCheck #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) i_descRightsCheck (
    .clk(clk), .rstN(rstN), .start(start), .selectorIn(selectorIn),
    .cpl(cpl), .longMode(longMode), .wideOp(wideOp),
    .gdtBase(GDT_BASE), .gdtLimit(gdtLimit),
    .ldtBase(LDT_BASE), .ldtLimit(ldtLimit),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .done(done), .accessOk(accessOk), .rights(rights)
  );

  always @(posedge clk) if (memRdEn) memRdData <= mem[memRdAddr[11:2]];

  always @(negedge clk) begin
    cycles++;
    if (memRdEn) begin
      rdCount++;
      lastAddr = memRdAddr;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] descWord(input logic [31:0] sel);
    logic [31:0] base, addr;
    base = sel[2] ? LDT_BASE : GDT_BASE;
    addr = base + {16'd0, sel[15:3], 3'b100};
    return mem[addr[11:2]];
  endfunction

  task automatic runOp(input logic [31:0] sel, input logic [1:0] cplV,
                       input bit lm, input bit wd, input string tag);
    logic [15:0] s;
    int          lim, lastB, lat;
    bit          early, expOk, typeOk, privOk, conf;
    logic [31:0] hi, expR, expAddr;
    logic [3:0]  t;
    logic [1:0]  dpl;
    logic [15:0] mask;
    s       = sel[15:0];
    lim     = s[2] ? int'(ldtLimit) : int'(gdtLimit);
    lastB   = int'(s[15:3]) * 8 + 7;
    early   = (s[15:2] == 14'd0) || (lastB > lim);
    expOk   = 1'b0;
    expR    = heldRights;
    expAddr = (s[2] ? LDT_BASE : GDT_BASE) + {16'd0, s[15:3], 3'b100};
    if (!early) begin
      hi     = descWord(sel);
      t      = hi[11:8];
      dpl    = hi[14:13];
      mask   = lm ? 16'h1A00 : 16'h1A3E;
      typeOk = hi[12] || mask[t];
      conf   = hi[12] && t[3] && t[2];
      privOk = conf || ((cplV <= dpl) && (s[1:0] <= dpl));
      expOk  = typeOk && privOk;
      if (expOk) begin
        expR = {16'd0, hi[15:8], 8'd0};
        if (wd) expR[23:20] = hi[23:20];
      end
    end
    @(negedge clk);
    selectorIn = sel; cpl = cplV; longMode = lm; wideOp = wd;
    start = 1'b1;
    rdCount = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == (early ? 2 : 4), early ? "R2" : "R4", "latency", lat, early ? 2 : 4);
    chk(accessOk == expOk, tag, "accessOk", {31'd0, accessOk}, {31'd0, expOk});
    chk(rights == expR, expOk ? tag : "R11", "rights", rights, expR);
    chk(rdCount == (early ? 0 : 1), early ? "R3" : "R4", "read count", rdCount, early ? 0 : 1);
    if (!early) chk(lastAddr == expAddr, "R4", "read address", lastAddr, expAddr);
    heldRights = expR;
    @(negedge clk);
    chk(done == 1'b0, "R12", "done width", {31'd0, done}, 32'd0);
  endtask

  task automatic putDesc(input logic [31:0] sel, input logic [31:0] hi);
    logic [31:0] base, addr;
    base = sel[2] ? LDT_BASE : GDT_BASE;
    addr = base + {16'd0, sel[15:3], 3'b100};
    mem[addr[11:2]] = hi;
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && accessOk == 1'b0 && rights == 32'd0 && memRdEn == 1'b0,
        "R11", "reset state", {done, accessOk, memRdEn, rights[28:0]}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // layouts, upper selector bits
    putDesc(32'h0000_000B, 32'hABDF_F2CD);
    runOp(32'h0000_000B, 2'd3, 1'b0, 1'b1, "R10");
    chk(rights == 32'h00D0_F200, "R10", "wide word", rights, 32'h00D0_F200);
    runOp(32'h0000_000B, 2'd3, 1'b0, 1'b0, "R9");
    chk(rights == 32'h0000_F200, "R9", "narrow word", rights, 32'h0000_F200);
    runOp(32'hDEAD_000B, 2'd3, 1'b0, 1'b1, "R1");

    // null selectors
    runOp(32'h0000_0000, 2'd0, 1'b0, 1'b1, "R2");
    runOp(32'h0000_0003, 2'd0, 1'b0, 1'b1, "R2");
    runOp(32'hFFFF_0002, 2'd0, 1'b0, 1'b1, "R1");
    putDesc(32'h0000_0004, 32'h0000_F200);
    runOp(32'h0000_0004, 2'd0, 1'b0, 1'b1, "R3");

    // limit boundary
    gdtLimit = 16'h0027;
    putDesc(32'h0000_0020, 32'h0000_F200);
    runOp(32'h0000_0020, 2'd0, 1'b0, 1'b0, "R3");
    runOp(32'h0000_0028, 2'd0, 1'b0, 1'b0, "R3");
    gdtLimit = 16'h03FF;
    ldtLimit = 16'h000F;
    runOp(32'h0000_000C, 2'd0, 1'b0, 1'b0, "R3");
    ldtLimit = 16'h01FF;

    // privilege
    putDesc(32'h0000_0010, 32'h0000_9A00);
    runOp(32'h0000_0010, 2'd3, 1'b0, 1'b1, "R8");
    runOp(32'h0000_0010, 2'd0, 1'b0, 1'b1, "R8");
    runOp(32'h0000_0011, 2'd0, 1'b0, 1'b1, "R8");
    putDesc(32'h0000_0018, 32'h0000_9E00);
    runOp(32'h0000_001B, 2'd3, 1'b0, 1'b1, "R8");

    // system type tables and code/data types
    for (int t = 0; t < 16; t++) begin
      putDesc(32'h0000_0030, {16'd0, 4'hE, t[3:0], 8'd0});
      runOp(32'h0000_0030, 2'd0, 1'b0, 1'b1, "R6");
      runOp(32'h0000_0030, 2'd0, 1'b1, 1'b1, "R7");
      putDesc(32'h0000_0030, {16'd0, 4'hF, t[3:0], 8'd0});
      runOp(32'h0000_0033, 2'd3, 1'b1, 1'b0, "R5");
    end

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] sel;
      if (n % 50 == 0) begin
        gdtLimit = 16'($urandom_range(0, 1023));
        ldtLimit = 16'($urandom_range(0, 1023));
      end
      if (n % 5 == 0) mem[$urandom_range(0, 1023)] = $urandom;
      sel = $urandom;
      sel[15:3] = 13'($urandom_range(0, 130));
      runOp(sel, 2'($urandom), 1'($urandom), 1'($urandom), "R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule